// File: doc/BRIEF.md
# Multi-function ALU

This block is the arithmetic-logic unit of a small 32-bit RISC datapath. It takes two operands and a 4-bit operation code and, with no clock and no internal state, produces a result word, a flag that says the result is all zeros, and a flag for signed two's-complement overflow. The decode stage sets the operation code. The branch logic looks at the zero flag after a subtract to decide whether two registers are equal.

Only one adder and one bitwise AND array are built. A subtract sends the inverted second operand into the adder and holds its carry-in high. A NOR sends both operands, inverted, into the AND array. A single result multiplexer, steered by the operation code, chooses which unit's output reaches the port. The overflow flag compares the carry that enters the top bit with the carry that leaves it.

Top module: `multi_alu`

## Requirements
- R1: Operation code 4'b0000 gives result = A AND B, bit by bit.
- R2: Operation code 4'b0001 gives result = A OR B, bit by bit.
- R3: Operation code 4'b0010 gives result = (A + B) modulo 2^32.
- R4: Operation code 4'b0110 gives result = (A - B) modulo 2^32.
- R5: Operation code 4'b1100 gives result = NOT (A OR B), bit by bit.
- R6: Any operation code other than those five gives result 0 and overflow 0.
- R7: The zero output is 1 exactly when all 32 result bits are 0, for every operation code.
- R8: For add, overflow is 1 exactly when A and B have the same sign bit (bit 31) and the result's sign bit differs from it.
- R9: For subtract, overflow is 1 exactly when A and B have different sign bits and the result's sign bit differs from A's.
- R10: For AND, OR and NOR, overflow is 0 whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand (minuend for subtract) |
| op_b | input | 32 | Second operand (subtrahend for subtract) |
| op_sel | input | 4 | Operation code |
| result | output | 32 | Output chosen by the result multiplexer |
| zero | output | 1 | High when result is all zeros |
| ovf | output | 1 | Signed overflow, for add and subtract only |

## Verification
The bench targets the edges of signed overflow: largest positive plus one, most negative plus most negative, most negative minus one, and zero minus the most negative value. A design that used only the carry out of bit 31, or that forgot to invert B for subtract, would flag the wrong cases in this set. It checks that a subtract of equal operands and a wrapping add of -1 and +1 raise zero without overflow. A design that took the carry-in from the wrong place would fail these. It runs every undefined operation code with busy operands. A decoder that fell through to a live unit would leak data or a stale overflow. It also checks that NOR taken through the shared AND array matches the complement of OR, which catches a design that inverts only one of the two operands.

// File: rtl/multi_alu_pkg.sv
// Package: shared width and operation codes for the multi-function ALU.
// Assumes: the operation codes below are the only ones with a defined result.
package multi_alu_pkg;

    localparam int unsigned ALU_W = 32;

    typedef enum logic [3:0] {
        OP_AND = 4'b0000,
        OP_OR  = 4'b0001,
        OP_ADD = 4'b0010,
        OP_SUB = 4'b0110,
        OP_NOR = 4'b1100
    } alu_op_e;

endpackage

// File: rtl/alu_addsub.sv
// Module: ripple-carry adder that also subtracts. For a subtract it takes
// the inverted B and holds the carry-in high. Signed overflow is the XOR
// of the carry into the top bit and the carry out of it.
// Assumes: W >= 2. Purely combinational.
module alu_addsub #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         do_sub,
    output logic [W-1:0] sum_out,
    output logic         ovf_out
);

    logic [W-1:0] b_eff;
    logic [W:0]   carry;

    // Choose B or its inverse for the adder.
    always_comb begin
        b_eff = do_sub ? ~b_in : b_in;
    end

    // Ripple the carry one full-adder bit at a time.
    always_comb begin
        carry[0] = do_sub;
        for (int i = 0; i < W; i++) begin
            sum_out[i]   = a_in[i] ^ b_eff[i] ^ carry[i];
            carry[i+1]   = (a_in[i] & b_eff[i]) | (carry[i] & (a_in[i] ^ b_eff[i]));
        end
    end

    // Flag overflow when the carries on either side of the top bit disagree.
    always_comb begin
        ovf_out = carry[W] ^ carry[W-1];
    end

endmodule

// File: rtl/alu_logic.sv
// Module: bitwise logic unit. One AND array serves both AND and NOR. For a
// NOR, both inputs are inverted first, which uses (A|B)' = A'&B'.
// Assumes: purely combinational; inv_in is high only for NOR.
module alu_logic #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         inv_in,
    output logic [W-1:0] and_out,
    output logic [W-1:0] or_out
);

    logic [W-1:0] a_eff;
    logic [W-1:0] b_eff;

    // Invert both operands when a NOR is wanted.
    always_comb begin
        a_eff = inv_in ? ~a_in : a_in;
        b_eff = inv_in ? ~b_in : b_in;
    end

    // Shared AND array, and the OR array.
    always_comb begin
        and_out = a_eff & b_eff;
        or_out  = a_in | b_in;
    end

endmodule

// File: rtl/alu_result_mux.sv
// Module: result multiplexer. It picks one unit's output by operation code
// and lets the adder's overflow through only for add and subtract.
// Assumes: undefined codes must produce zero with no overflow.
module alu_result_mux #(
    parameter int unsigned W = 32
) (
    input  multi_alu_pkg::alu_op_e op_in,
    input  logic [W-1:0]           and_in,
    input  logic [W-1:0]           or_in,
    input  logic [W-1:0]           sum_in,
    input  logic                   ovf_in,
    output logic [W-1:0]           res_out,
    output logic                   ovf_out
);

    import multi_alu_pkg::*;

    // Pick the result and mask the overflow by operation.
    always_comb begin
        res_out = '0;
        ovf_out = 1'b0;
        unique case (op_in)
            OP_AND:  res_out = and_in;
            OP_NOR:  res_out = and_in;
            OP_OR:   res_out = or_in;
            OP_ADD,
            OP_SUB: begin
                res_out = sum_in;
                ovf_out = ovf_in;
            end
            default: begin
                res_out = '0;
                ovf_out = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/multi_alu.sv
// Module: top of the 32-bit multi-function ALU. It decodes the operation
// code into steering for the shared adder and AND array, and works out the
// zero flag from the final result.
// Assumes: combinational use with no clock; the operands settle within the
// cycle of the datapath around it.
module multi_alu #(
    parameter int unsigned W = multi_alu_pkg::ALU_W
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [3:0]   op_sel,
    output logic [W-1:0] result,
    output logic         zero,
    output logic         ovf
);

    import multi_alu_pkg::*;

    alu_op_e      op;
    logic         sub_sel;
    logic         nor_sel;
    logic [W-1:0] sum_w;
    logic         add_ovf;
    logic [W-1:0] and_w;
    logic [W-1:0] or_w;

    // Decode the operation code into steering bits.
    always_comb begin
        op      = alu_op_e'(op_sel);
        sub_sel = (op_sel == OP_SUB);
        nor_sel = (op_sel == OP_NOR);
    end

    alu_addsub #(.W(W)) i_addsub (
        .a_in    (op_a),
        .b_in    (op_b),
        .do_sub  (sub_sel),
        .sum_out (sum_w),
        .ovf_out (add_ovf)
    );

    alu_logic #(.W(W)) i_logic (
        .a_in    (op_a),
        .b_in    (op_b),
        .inv_in  (nor_sel),
        .and_out (and_w),
        .or_out  (or_w)
    );

    alu_result_mux #(.W(W)) i_mux (
        .op_in   (op),
        .and_in  (and_w),
        .or_in   (or_w),
        .sum_in  (sum_w),
        .ovf_in  (add_ovf),
        .res_out (result),
        .ovf_out (ovf)
    );

    // Set the zero flag when no result bit is high.
    always_comb begin
        zero = ~|result;
    end

endmodule

// File: rtl/multi_alu_checker.sv
// Module: assertion checker for multi_alu, attached with bind. The block has
// no clock, so every check is an immediate assertion that is evaluated
// whenever the ports change.
// Assumes: the port values are known (not X or Z) when they are checked.
module multi_alu_checker #(
    parameter int unsigned W = 32
) (
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic [3:0]   op_sel,
    input logic [W-1:0] result,
    input logic         zero,
    input logic         ovf
);

    logic defined_op;
    logic logical_op;

    // Sort the operation code into defined and logical.
    always_comb begin
        defined_op = (op_sel == 4'b0000) || (op_sel == 4'b0001) || (op_sel == 4'b0010)
                  || (op_sel == 4'b0110) || (op_sel == 4'b1100);
        logical_op = (op_sel == 4'b0000) || (op_sel == 4'b0001) || (op_sel == 4'b1100);
    end

    // Compare the port behaviour with the requirements.
    always_comb begin
        if (!$isunknown({op_a, op_b, op_sel, result, zero, ovf})) begin
            if (op_sel == 4'b0010)
                p_add_sum_r3: assert (result == op_a + op_b);
            if (op_sel == 4'b0110)
                p_sub_diff_r4: assert (result == op_a - op_b);
            if (op_sel == 4'b1100)
                p_nor_value_r5: assert (result == ~(op_a | op_b));
            if (!defined_op)
                p_undef_quiet_r6: assert (result == '0 && !ovf);
            p_zero_flag_r7: assert (zero == (result == '0));
            if (op_sel == 4'b0010)
                p_add_ovf_r8: assert (ovf == ((op_a[W-1] == op_b[W-1]) && (result[W-1] != op_a[W-1])));
            if (op_sel == 4'b0110)
                p_sub_ovf_r9: assert (ovf == ((op_a[W-1] != op_b[W-1]) && (result[W-1] != op_a[W-1])));
            if (logical_op)
                p_no_overflow_r10: assert (!ovf);
        end
    end

endmodule

bind multi_alu multi_alu_checker #(.W(W)) i_multi_alu_checker (
    .op_a   (op_a),
    .op_b   (op_b),
    .op_sel (op_sel),
    .result (result),
    .zero   (zero),
    .ovf    (ovf)
);

// File: tb/test_multi_alu.sv
// Bench: directed tests for multi_alu, one task per scenario. Each expected
// value is worked out here from the requirements.
module test_multi_alu;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned W = 32;

    logic         clk = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [3:0]   op_sel = 4'b0000;
    logic [W-1:0] result;
    logic         zero;
    logic         ovf;

    int checks = 0;
    int errors = 0;

    multi_alu #(.W(W)) i_multi_alu (
        .op_a   (op_a),
        .op_b   (op_b),
        .op_sel (op_sel),
        .result (result),
        .zero   (zero),
        .ovf    (ovf)
    );

    // Free-running clock that paces the stimulus.
    always #(CLK_PERIOD/2) clk = ~clk;

    // Drive the operands on a falling edge and sample mid-phase.
    task automatic apply(input logic [3:0] s, input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        op_sel = s;
        op_a   = a;
        op_b   = b;
        #(CLK_PERIOD/4);
    endtask

    // Compare all three outputs with their expected values.
    task automatic check(input string req, input logic [W-1:0] exp_r,
                         input logic exp_z, input logic exp_o);
        checks++;
        if (result !== exp_r || zero !== exp_z || ovf !== exp_o) begin
            errors++;
            $display("FAIL %s: sel=%b a=%h b=%h actual r=%h z=%b o=%b expected r=%h z=%b o=%b",
                     req, op_sel, op_a, op_b, result, zero, ovf, exp_r, exp_z, exp_o);
        end
    endtask

    // Initial state: all inputs zero, AND gives zero with the flag set (R1, R7).
    task automatic t_initial();
        apply(4'b0000, '0, '0);
        check("R7", '0, 1'b1, 1'b0);
    endtask

    // Logical operations on several patterns (R1, R2, R5, R10).
    task automatic t_logic();
        logic [W-1:0] pa [3];
        logic [W-1:0] pb [3];
        pa = '{32'hF0F0_1234, 32'hFFFF_FFFF, 32'h8000_0001};
        pb = '{32'h0FF0_FFFF, 32'h7FFF_FFFF, 32'h8000_0001};
        for (int k = 0; k < 3; k++) begin
            apply(4'b0000, pa[k], pb[k]);
            check("R1", pa[k] & pb[k], (pa[k] & pb[k]) == '0, 1'b0);
            apply(4'b0001, pa[k], pb[k]);
            check("R2", pa[k] | pb[k], (pa[k] | pb[k]) == '0, 1'b0);
            apply(4'b1100, pa[k], pb[k]);
            check("R5", ~(pa[k] | pb[k]), ~(pa[k] | pb[k]) == '0, 1'b0);
        end
        apply(4'b1100, '0, '0);
        check("R5", 32'hFFFF_FFFF, 1'b0, 1'b0);
        apply(4'b0000, 32'hAAAA_AAAA, 32'h5555_5555);
        check("R10", '0, 1'b1, 1'b0);
    endtask

    // Add cases, including the overflow edges (R3, R8).
    task automatic t_add();
        apply(4'b0010, 32'd1234, 32'd4321);
        check("R3", 32'd5555, 1'b0, 1'b0);
        apply(4'b0010, 32'h7FFF_FFFF, 32'h0000_0001);
        check("R8", 32'h8000_0000, 1'b0, 1'b1);
        apply(4'b0010, 32'h8000_0000, 32'h8000_0000);
        check("R8", 32'h0000_0000, 1'b1, 1'b1);
        apply(4'b0010, 32'hFFFF_FFFF, 32'h0000_0001);
        check("R3", 32'h0000_0000, 1'b1, 1'b0);
        apply(4'b0010, 32'hFFFF_FFFE, 32'hFFFF_FFFD);
        check("R8", 32'hFFFF_FFFB, 1'b0, 1'b0);
    endtask

    // Subtract cases, including the overflow edges and equal operands (R4, R9, R7).
    task automatic t_sub();
        apply(4'b0110, 32'd100, 32'd58);
        check("R4", 32'd42, 1'b0, 1'b0);
        apply(4'b0110, 32'd5, 32'd9);
        check("R4", 32'hFFFF_FFFC, 1'b0, 1'b0);
        apply(4'b0110, 32'h1357_9BDF, 32'h1357_9BDF);
        check("R7", '0, 1'b1, 1'b0);
        apply(4'b0110, 32'h8000_0000, 32'h0000_0001);
        check("R9", 32'h7FFF_FFFF, 1'b0, 1'b1);
        apply(4'b0110, 32'h0000_0000, 32'h8000_0000);
        check("R9", 32'h8000_0000, 1'b0, 1'b1);
        apply(4'b0110, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
        check("R9", 32'h8000_0000, 1'b0, 1'b1);
        apply(4'b0110, 32'hFFFF_FFFF, 32'h7FFF_FFFF);
        check("R9", 32'h8000_0000, 1'b0, 1'b0);
    endtask

    // Every undefined code yields zero, zero flag, no overflow (R6).
    task automatic t_undefined();
        for (int c = 0; c < 16; c++) begin
            if (c != 0 && c != 1 && c != 2 && c != 6 && c != 12) begin
                apply(4'(c), 32'h7FFF_FFFF, 32'h7FFF_FFFF);
                check("R6", '0, 1'b1, 1'b0);
            end
        end
    endtask

    // Run the scenarios in order, then print the summary.
    initial begin
        t_initial();
        t_logic();
        t_add();
        t_sub();
        t_undefined();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: end a hung run as a failure.
    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule